// File: doc/BRIEF.md
# SPI Byte-to-Word Packer and Unpacker

This block connects a byte-wide stream to the 32-bit data ports of a serial controller's transmit and receive FIFOs. On the transmit side, it gathers bytes into FIFO words. The first byte of each word goes into the top lane. The number of bytes per word is set by the configured SPI word width. On the receive side, it takes right-justified FIFO words apart and emits them as bytes, most significant valid byte first. The receive side can also run without a destination. In that case it drains words and only counts them.

A pulse on `cfg_load` starts a transfer. The pulse latches the word width (as bits-per-word minus one), the transfer length in bytes and the discard flag. At the same time the block chooses between direct FIFO mode and block mode from the resulting word count, and it sets the two pairs of count values that a transfer engine expects for that mode. A `done` flag rises once the number of received bytes reaches the length.

Top module: `spi_word_packer`

## Requirements
- R1: The 5-bit width field holds bits-per-word minus one. A value of 7 or less gives 1 byte per word, 8 to 15 gives 2 bytes, and 16 to 31 gives 4 bytes. The word count is the length divided by that byte count, rounded down.
- R2: On transmit, the byte in lane i of a word (counting from 0 in arrival order) lands at bits 8*(3-i)+7 down to 8*(3-i). The word is written to the output FIFO in the same cycle as the handshake of its last lane.
- R3: The block never accepts more transmit bytes than the length. The final byte of the transfer closes its word early, and the unfilled low lanes of that word are zero.
- R4: While `ofifo_full` is high, `tx_byte_ready` and `ofifo_wr` stay low.
- R5: A received word holds its data in the low bytes, for example 0x00001234 for 2-byte words. Its bytes are emitted most significant valid byte first. The final word of a transfer emits only the bytes that fall within the length.
- R6: `ififo_rd` is never raised while `ififo_not_empty` is low, while a previous word is still being emitted, or once the receive byte count has reached the length.
- R7: With discard set, each word read from the input FIFO produces no output byte but adds one full word of bytes to the receive count.
- R8: FIFO mode (`mode_block` = 0) is chosen when the word count is at most IN_FIFO_BYTES/4. Otherwise block mode (`mode_block` = 1) is chosen.
- R9: In FIFO mode `rw_count` holds the word count and `io_count` is zero. In block mode the two are swapped.
- R10: `done` is high exactly when a transfer has been loaded and its receive byte count is at or above its length. It stays high until the next load.
- R11: After reset, `tx_byte_ready`, `ofifo_wr`, `ififo_rd`, `rx_byte_valid`, `done`, `mode_block`, `rw_count` and `io_count` are all zero.
- R12: A load restarts both byte counts and drops any partly built or partly emitted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Start a transfer with the settings below |
| cfg_bpw_m1 | input | 5 | Bits per SPI word minus one |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_rx_discard | input | 1 | Drop received data but still count it |
| tx_byte_valid | input | 1 | Transmit byte offered |
| tx_byte_data | input | 8 | Transmit byte |
| tx_byte_ready | output | 1 | Transmit byte accepted this cycle |
| ofifo_full | input | 1 | Output FIFO cannot take a word |
| ofifo_wr | output | 1 | Write strobe to output FIFO |
| ofifo_wdata | output | 32 | Packed word, first byte in the top lane |
| ififo_not_empty | input | 1 | Input FIFO has a word; data shown on `ififo_rdata` |
| ififo_rdata | input | 32 | Head word of input FIFO, right-justified |
| ififo_rd | output | 1 | Pop strobe to input FIFO |
| rx_byte_valid | output | 1 | Received byte offered |
| rx_byte_data | output | 8 | Received byte |
| rx_byte_ready | input | 1 | Consumer takes the received byte |
| mode_block | output | 1 | 0 = FIFO mode, 1 = block mode |
| rw_count | output | LEN_W | Read/write word count (FIFO mode) |
| io_count | output | LEN_W | Input/output word count (block mode) |
| done | output | 1 | Receive byte count has reached the length |

## Verification
The bound checker checks the flow-control rules on every cycle. These are the full-FIFO stall, the ban on popping an empty input FIFO or popping while a word is still held, the exclusive use of one count pair per mode, the stickiness of `done`, and that a FIFO write only happens on a byte handshake. Byte placement inside a word, the early close of a short last word, the right-justified unpacking order, the discard counting and the threshold where the mode changes all depend on particular data and lengths. Only the bench's scenarios and its configuration table can show those.

// File: rtl/spw_pkg.sv
// Shared types and helpers for the SPI word packer.
// Assumes a 32-bit FIFO word and byte-wide streams.
package spw_pkg;

    localparam int unsigned WORD_BITS  = 32;
    localparam int unsigned WORD_BYTES = WORD_BITS / 8;

    typedef enum logic {
        XFER_FIFO  = 1'b0,
        XFER_BLOCK = 1'b1
    } xfer_mode_e;

    // Number of bytes a word of (bpw_m1 + 1) bits occupies in the FIFO.
    function automatic logic [2:0] bytes_for_bpw(input logic [4:0] bpw_m1);
        if (bpw_m1 <= 5'd7)       return 3'd1;
        else if (bpw_m1 <= 5'd15) return 3'd2;
        else                      return 3'd4;
    endfunction

endpackage

// File: rtl/spw_cfg_unit.sv
// Latches the transfer settings on a load pulse and derives the word
// count, the transfer mode and the per-mode count values.
// Assumes cfg_load is a single-cycle pulse; settings are sampled with it.
module spw_cfg_unit #(
    parameter int unsigned LEN_W         = 16,
    parameter int unsigned IN_FIFO_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [4:0]       cfg_bpw_m1,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_rx_discard,
    output logic             active,
    output logic [2:0]       nbytes,
    output logic [LEN_W-1:0] len_q,
    output logic             discard_q,
    output logic             mode_block,
    output logic [LEN_W-1:0] rw_count,
    output logic [LEN_W-1:0] io_count
);
    import spw_pkg::*;

    localparam int unsigned FIFO_WORDS = IN_FIFO_BYTES / WORD_BYTES;
    localparam logic [LEN_W:0] FIFO_WORDS_L = (LEN_W+1)'(FIFO_WORDS);

    logic [2:0]       nb_in;
    logic [LEN_W-1:0] words_in;
    xfer_mode_e       mode_in;

    // Decode bytes per word and the word count from the incoming settings.
    always_comb begin
        nb_in = bytes_for_bpw(cfg_bpw_m1);
        case (nb_in)
            3'd1:    words_in = cfg_len;
            3'd2:    words_in = cfg_len >> 1;
            default: words_in = cfg_len >> 2;
        endcase
        mode_in = ({1'b0, words_in} <= FIFO_WORDS_L) ? XFER_FIFO : XFER_BLOCK;
    end

    // Register settings, mode and count pair on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            nbytes     <= 3'd1;
            len_q      <= '0;
            discard_q  <= 1'b0;
            mode_block <= 1'b0;
            rw_count   <= '0;
            io_count   <= '0;
        end else if (cfg_load) begin
            active     <= 1'b1;
            nbytes     <= nb_in;
            len_q      <= cfg_len;
            discard_q  <= cfg_rx_discard;
            mode_block <= (mode_in == XFER_BLOCK);
            rw_count   <= (mode_in == XFER_FIFO)  ? words_in : '0;
            io_count   <= (mode_in == XFER_BLOCK) ? words_in : '0;
        end
    end

endmodule

// File: rtl/spw_tx_packer.sv
// Packs transmit bytes into 32-bit FIFO words, first byte in the top lane.
// A word is written in the cycle its last byte is accepted, so a byte is
// only accepted while the output FIFO has room. Assumes nbytes is 1, 2 or 4.
module spw_tx_packer #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic [2:0]       nbytes,
    input  logic [LEN_W-1:0] len_q,
    input  logic             tx_byte_valid,
    input  logic [7:0]       tx_byte_data,
    output logic             tx_byte_ready,
    input  logic             ofifo_full,
    output logic             ofifo_wr,
    output logic [31:0]      ofifo_wdata
);
    logic [LEN_W-1:0] sent;
    logic [1:0]       lane;
    logic [31:0]      acc;
    logic             take;
    logic             last_lane;
    logic             last_byte;
    logic [4:0]       shamt;

    // Handshake, lane placement and word-close decision.
    always_comb begin
        tx_byte_ready = active && !ofifo_full && (sent < len_q);
        take          = tx_byte_valid && tx_byte_ready;
        last_lane     = ({1'b0, lane} == (nbytes - 3'd1));
        last_byte     = (({1'b0, sent} + 1'b1) == {1'b0, len_q});
        shamt         = {2'd3 - lane, 3'b000};
        ofifo_wdata   = acc | ({24'b0, tx_byte_data} << shamt);
        ofifo_wr      = take && (last_lane || last_byte);
    end

    // Track sent bytes, current lane and the partial word.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sent <= '0;
            lane <= '0;
            acc  <= '0;
        end else if (take) begin
            sent <= sent + 1'b1;
            if (ofifo_wr) begin
                lane <= '0;
                acc  <= '0;
            end else begin
                lane <= lane + 1'b1;
                acc  <= ofifo_wdata;
            end
        end
    end

endmodule

// File: rtl/spw_rx_unpacker.sv
// Pops right-justified words from the input FIFO and emits their valid
// bytes most significant first, or counts them when discarding.
// Assumes ififo_rdata shows the head word while ififo_not_empty is high.
module spw_rx_unpacker #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic [2:0]       nbytes,
    input  logic [LEN_W-1:0] len_q,
    input  logic             discard_q,
    input  logic             ififo_not_empty,
    input  logic [31:0]      ififo_rdata,
    output logic             ififo_rd,
    output logic             rx_byte_valid,
    output logic [7:0]       rx_byte_data,
    input  logic             rx_byte_ready,
    output logic             done
);
    logic             held;
    logic [31:0]      word;
    logic [1:0]       lane;
    logic [LEN_W:0]   rcnt;
    logic             want;
    logic             take;
    logic             last;
    logic [5:0]       shamt;

    // Pop decision, byte selection and end-of-word detection.
    always_comb begin
        want          = (rcnt < {1'b0, len_q});
        ififo_rd      = active && !held && ififo_not_empty && want;
        rx_byte_valid = held;
        shamt         = {nbytes - 3'd1 - {1'b0, lane}, 3'b000};
        rx_byte_data  = 8'(word >> shamt);
        take          = held && rx_byte_ready;
        last          = ({1'b0, lane} == (nbytes - 3'd1)) ||
                        ((rcnt + 1'b1) == {1'b0, len_q});
        done          = active && !want;
    end

    // Hold the popped word, step through its lanes and count bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            held <= 1'b0;
            word <= '0;
            lane <= '0;
            rcnt <= '0;
        end else begin
            if (ififo_rd) begin
                if (discard_q) begin
                    rcnt <= rcnt + {{(LEN_W-2){1'b0}}, nbytes};
                end else begin
                    held <= 1'b1;
                    word <= ififo_rdata;
                    lane <= '0;
                end
            end
            if (take) begin
                rcnt <= rcnt + 1'b1;
                lane <= lane + 1'b1;
                if (last) held <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_word_packer.sv
// Top level: byte/word conversion between a byte stream and the 32-bit
// FIFO ports of a serial controller, with mode choice and completion flag.
// Assumes the FIFOs and the serial shifter live outside this block.
module spi_word_packer #(
    parameter int unsigned LEN_W         = 16,
    parameter int unsigned IN_FIFO_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [4:0]       cfg_bpw_m1,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_rx_discard,
    input  logic             tx_byte_valid,
    input  logic [7:0]       tx_byte_data,
    output logic             tx_byte_ready,
    input  logic             ofifo_full,
    output logic             ofifo_wr,
    output logic [31:0]      ofifo_wdata,
    input  logic             ififo_not_empty,
    input  logic [31:0]      ififo_rdata,
    output logic             ififo_rd,
    output logic             rx_byte_valid,
    output logic [7:0]       rx_byte_data,
    input  logic             rx_byte_ready,
    output logic             mode_block,
    output logic [LEN_W-1:0] rw_count,
    output logic [LEN_W-1:0] io_count,
    output logic             done
);
    logic             active;
    logic [2:0]       nbytes;
    logic [LEN_W-1:0] len_q;
    logic             discard_q;

    spw_cfg_unit #(.LEN_W(LEN_W), .IN_FIFO_BYTES(IN_FIFO_BYTES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_bpw_m1(cfg_bpw_m1), .cfg_len(cfg_len), .cfg_rx_discard(cfg_rx_discard),
        .active(active), .nbytes(nbytes), .len_q(len_q), .discard_q(discard_q),
        .mode_block(mode_block), .rw_count(rw_count), .io_count(io_count)
    );

    spw_tx_packer #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .restart(cfg_load), .active(active),
        .nbytes(nbytes), .len_q(len_q),
        .tx_byte_valid(tx_byte_valid), .tx_byte_data(tx_byte_data),
        .tx_byte_ready(tx_byte_ready), .ofifo_full(ofifo_full),
        .ofifo_wr(ofifo_wr), .ofifo_wdata(ofifo_wdata)
    );

    spw_rx_unpacker #(.LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .restart(cfg_load), .active(active),
        .nbytes(nbytes), .len_q(len_q), .discard_q(discard_q),
        .ififo_not_empty(ififo_not_empty), .ififo_rdata(ififo_rdata),
        .ififo_rd(ififo_rd), .rx_byte_valid(rx_byte_valid),
        .rx_byte_data(rx_byte_data), .rx_byte_ready(rx_byte_ready), .done(done)
    );

endmodule

// File: rtl/spw_packer_checker.sv
// Cycle-level rules for spi_word_packer, attached through bind.
module spw_packer_checker #(
    parameter int unsigned LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic             tx_byte_valid,
    input logic             tx_byte_ready,
    input logic             ofifo_full,
    input logic             ofifo_wr,
    input logic             ififo_not_empty,
    input logic             ififo_rd,
    input logic             rx_byte_valid,
    input logic             mode_block,
    input logic [LEN_W-1:0] rw_count,
    input logic [LEN_W-1:0] io_count,
    input logic             done
);
    assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ofifo_full |-> (!tx_byte_ready && !ofifo_wr));

    assert_wr_on_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ofifo_wr |-> (tx_byte_valid && tx_byte_ready));

    assert_no_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ififo_not_empty |-> !ififo_rd);

    assert_no_pop_while_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_valid |-> !ififo_rd);

    assert_count_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_block ? (rw_count == '0) : (io_count == '0));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_load) |=> done);

    assert_done_pops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ififo_rd);
endmodule

bind spi_word_packer spw_packer_checker #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/spi_word_packer_tb.sv
`timescale 1ns/1ps
module spi_word_packer_tb;
    localparam int unsigned LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0;
    logic [4:0]       cfg_bpw_m1 = '0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic             cfg_rx_discard = 1'b0;
    logic             tx_byte_valid = 1'b0;
    logic [7:0]       tx_byte_data = '0;
    logic             tx_byte_ready;
    logic             ofifo_full = 1'b0;
    logic             ofifo_wr;
    logic [31:0]      ofifo_wdata;
    logic             ififo_not_empty = 1'b0;
    logic [31:0]      ififo_rdata = '0;
    logic             ififo_rd;
    logic             rx_byte_valid;
    logic [7:0]       rx_byte_data;
    logic             rx_byte_ready = 1'b1;
    logic             mode_block;
    logic [LEN_W-1:0] rw_count;
    logic [LEN_W-1:0] io_count;
    logic             done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spi_word_packer #(.LEN_W(LEN_W), .IN_FIFO_BYTES(64)) u_dut (.*);

    // {bpw_m1, len, expect block, expect word count}
    localparam logic [37:0] CFG_VEC [8] = '{
        {5'd7,  16'd16, 1'b0, 16'd16},
        {5'd7,  16'd17, 1'b1, 16'd17},
        {5'd15, 16'd32, 1'b0, 16'd16},
        {5'd15, 16'd34, 1'b1, 16'd17},
        {5'd31, 16'd64, 1'b0, 16'd16},
        {5'd31, 16'd68, 1'b1, 16'd17},
        {5'd3,  16'd5,  1'b0, 16'd5},
        {5'd16, 16'd6,  1'b0, 16'd1}
    };

    logic [31:0] wq [8];
    int          nw;
    logic [31:0] rx_mem [4];
    logic [7:0]  rx_got [8];
    int          n_got;
    int          n_rd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-side FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [4:0] bpw, input logic [15:0] len, input logic disc);
        @(negedge clk);
        cfg_bpw_m1 = bpw; cfg_len = len; cfg_rx_discard = disc; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        tx_byte_valid = 1'b1; tx_byte_data = b;
        #1;
        while (!tx_byte_ready) begin @(negedge clk); #1; end
        if (ofifo_wr) begin wq[nw] = ofifo_wdata; nw++; end
        @(negedge clk);
        tx_byte_valid = 1'b0;
    endtask

    task automatic run_rx(input int n_words, input int cycles);
        int ri = 0;
        n_got = 0; n_rd = 0;
        for (int c = 0; c < cycles; c++) begin
            ififo_not_empty = (ri < n_words);
            ififo_rdata     = (ri < n_words) ? rx_mem[ri] : 32'h0;
            #1;
            if (rx_byte_valid && n_got < 8) begin rx_got[n_got] = rx_byte_data; n_got++; end
            if (ififo_rd) begin n_rd++; ri++; end
            @(negedge clk);
        end
        ififo_not_empty = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready", {31'b0, tx_byte_ready}, 0);
        chk("R11 wr", {31'b0, ofifo_wr}, 0);
        chk("R11 rd", {31'b0, ififo_rd}, 0);
        chk("R11 done", {31'b0, done}, 0);
        chk("R11 counts", {mode_block, rw_count, io_count[14:0]}, 0);
        rst_n = 1'b1;

        // R1 R8 R9 configuration table
        for (int i = 0; i < 8; i++) begin
            load(CFG_VEC[i][37:33], CFG_VEC[i][32:17], 1'b0);
            chk("R8 mode", {31'b0, mode_block}, {31'b0, CFG_VEC[i][16]});
            chk("R1 R9 count", {rw_count, io_count},
                CFG_VEC[i][16] ? {16'd0, CFG_VEC[i][15:0]} : {CFG_VEC[i][15:0], 16'd0});
        end

        // R2 R3 two-byte words, length 5
        load(5'd15, 16'd5, 1'b0);
        nw = 0;
        push(8'h11); push(8'h22); push(8'h33); push(8'h44); push(8'h55);
        chk("R2 words", nw, 3);
        chk("R2 word0", wq[0], 32'h1122_0000);
        chk("R2 word1", wq[1], 32'h3344_0000);
        chk("R3 short word", wq[2], 32'h5500_0000);
        tx_byte_valid = 1'b1; #1;
        chk("R3 no extra byte", {31'b0, tx_byte_ready}, 0);
        @(negedge clk); tx_byte_valid = 1'b0;

        // R2 four-byte word; R4 full stall
        load(5'd31, 16'd4, 1'b0);
        nw = 0;
        ofifo_full = 1'b1; tx_byte_valid = 1'b1; tx_byte_data = 8'hA1; #1;
        chk("R4 ready while full", {31'b0, tx_byte_ready}, 0);
        chk("R4 wr while full", {31'b0, ofifo_wr}, 0);
        @(negedge clk); ofifo_full = 1'b0;
        push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
        chk("R2 one word", nw, 1);
        chk("R2 full word", wq[0], 32'hA1A2_A3A4);

        // R2 one-byte words
        load(5'd7, 16'd2, 1'b0);
        nw = 0;
        push(8'h5A); push(8'h6B);
        chk("R2 byte word0", wq[0], 32'h5A00_0000);
        chk("R2 byte word1", wq[1], 32'h6B00_0000);

        // R5 R6 R10 receive, 2-byte words, length 3
        load(5'd15, 16'd3, 1'b0);
        chk("R10 not done", {31'b0, done}, 0);
        rx_mem[0] = 32'h0000_1234; rx_mem[1] = 32'h0000_ABCD; rx_mem[2] = 32'h0000_7777;
        run_rx(3, 12);
        chk("R5 count", n_got, 3);
        chk("R5 bytes", {8'h0, rx_got[0], rx_got[1], rx_got[2]}, 32'h0012_34AB);
        chk("R6 reads stop at length", n_rd, 2);
        chk("R10 done", {31'b0, done}, 1);

        // R6 empty FIFO never popped
        load(5'd7, 16'd4, 1'b0);
        run_rx(0, 4);
        chk("R6 empty pop", n_rd, 0);
        chk("R10 done low", {31'b0, done}, 0);

        // R7 discard: 4-byte words, length 6
        load(5'd31, 16'd6, 1'b1);
        rx_mem[0] = 32'h1111_1111; rx_mem[1] = 32'h2222_2222; rx_mem[2] = 32'h3333_3333;
        run_rx(3, 8);
        chk("R7 no bytes", n_got, 0);
        chk("R7 reads", n_rd, 2);
        chk("R7 done", {31'b0, done}, 1);

        // R12 reload clears counts
        load(5'd31, 16'd6, 1'b0);
        chk("R12 done cleared", {31'b0, done}, 0);
        tx_byte_valid = 1'b1; #1;
        chk("R12 tx restarts", {31'b0, tx_byte_ready}, 1);
        @(negedge clk); tx_byte_valid = 1'b0;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule